// File: doc/BRIEF.md
# SPI Flash User-Command Sequencer

This block is a register-programmed SPI master for serial NOR flash. Software fills a small set of configuration registers and a 64-byte data buffer, then sets a trigger bit. The block then runs exactly one transaction on the single-wire SPI pins. A transaction is built from up to four phases that always come in the same order: opcode, address, write data and read data. Each phase has its own enable bit and its own bit count, and disabled phases are skipped without gaps. Chip select is not generated here; the surrounding logic holds it active around the transaction.

The trigger bit doubles as the busy flag. It reads 1 for as long as the transaction runs and clears itself at the end. SCK runs at half the system clock with SPI mode 0 timing. Outgoing write data is taken from the buffer and incoming read data is stored back into the buffer. In both directions the buffer is walked from word 0, low byte first, most significant bit first within each byte.

The sequencer states are IDLE, OPCODE, ADDRESS, WDATA, RDATA and FINISH. The transitions are:
- IDLE to the first enabled phase when triggered, or to FINISH if no phase is enabled.
- A phase to the next enabled phase, or to FINISH, after its last bit's falling SCK edge.
- FINISH to IDLE one clock later.

Top module: `spi_user_seq`

## Requirements
- R1: Writing offset 0x00 with bit 18 set while idle starts a transaction. Bit 18 of offset 0x00 then reads 1 for exactly 2*T+1 clocks, where T is the total number of bits of the enabled phases, and then reads 0 again.
- R2: Phase enables are in the user register at offset 0x1C: bit 31 opcode, bit 30 address, bit 27 write data, bit 28 read data. Enabled phases run in the order opcode, address, write data, read data.
- R3: The opcode phase sends user2[31:28]+1 bits (user2 at 0x24), starting with user2[7] and continuing downward through user2[0], with zeros sent after the eighth bit.
- R4: The address phase sends the 0x04 register MSB first. Its bit count is user1[31:26]+1 (user1 at 0x20). When user bit 1 is clear, the count is capped at 24, so only address bits 31..8 go out.
- R5: The write data phase sends user1[25:17]+1 bits from the buffer. The buffer starts at word 0 (offset 0x40). Within each word, bits 7:0 go first, then 15:8, then 23:16, then 31:24, each byte MSB first.
- R6: The read data phase receives user1[16:8]+1 bits from MISO and stores them into the buffer in the same order as R5. Buffer bits beyond the count keep their values, and MOSI is 0 during this phase.
- R7: SCK idles low. Each bit takes one clock with SCK low followed by one clock with SCK high. MOSI changes only while SCK is low, and MISO is sampled at the rising SCK edge.
- R8: Consecutive enabled phases follow each other with no idle SCK periods between them.
- R9: While busy, writes to the address, user, user1, user2 and buffer registers, and any further trigger, have no effect.
- R10: A trigger with no phase enabled produces no SCK edge and keeps busy high for one clock only.
- R11: Registers read back at 0x00 (bit 18 only), 0x04, 0x1C, 0x20 and 0x24, and buffer word k at 0x40+4k.
- R12: After reset all registers and the buffer read 0, and SCK and MOSI are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (7) | Byte offset of register or buffer word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The bench exercises the following corner cases:
- The 24-bit cap on an address count of 32. Without it, eight extra address bits would go out and busy would stretch by 16 clocks.
- A full 512-bit write followed by a 512-bit read. A wrong byte-lane or bit-order mapping shows up as mismatched MOSI bits and buffer words.
- A 5-bit read. It must leave the rest of the buffer untouched; an engine that shifted whole words would corrupt it.
- An empty trigger, which must hold busy for a single clock.
- A 4-bit opcode.
- Attempts to rewrite configuration and buffer while busy. A design that accepted them would read back the new values.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CMD   = 3'd1,
        ST_ADDR  = 3'd2,
        ST_DOUT  = 3'd3,
        ST_DIN   = 3'd4,
        ST_DONE  = 3'd5
    } seq_state_t;

    localparam int LEN_W     = 9;   // data phase bit count field width
    localparam int OFF_CMD   = 'h00;
    localparam int OFF_ADDR  = 'h04;
    localparam int OFF_USER  = 'h1C;
    localparam int OFF_USER1 = 'h20;
    localparam int OFF_USER2 = 'h24;
    localparam int TRIG_BIT  = 18;
endpackage

// File: rtl/spi_seq_regs.sv
module spi_seq_regs
    import spi_seq_pkg::*;
#(
    parameter int BUF_WORDS = 16,
    localparam int WIX  = $clog2(BUF_WORDS),
    localparam int AW   = WIX + 3,
    localparam int BITW = $clog2(BUF_WORDS * 32)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    input  logic             busy,
    output logic             start,
    output logic [3:0]       ph_en,
    output logic             wide_addr,
    output logic [3:0]       cmd_len,
    output logic [5:0]       addr_len,
    output logic [LEN_W-1:0] dout_len,
    output logic [LEN_W-1:0] din_len,
    output logic [7:0]       opcode,
    output logic [31:0]      addr_word,
    input  logic [LEN_W-1:0] bit_idx,
    output logic             tx_bit,
    input  logic             rx_we,
    input  logic             rx_bit
);
    localparam int RW = AW - 1;

    logic [31:0] addr_q, user_q, user1_q, user2_q;
    logic [31:0] mem [BUF_WORDS];
    logic        wr_ok;
    logic [WIX-1:0] bw;
    logic [4:0]     bp;

    assign wr_ok = wr_en && !busy;
    assign start = wr_ok && (addr == AW'(OFF_CMD)) && wdata[TRIG_BIT];
    assign bw    = bit_idx[BITW-1:5];
    assign bp    = {bit_idx[4:3], ~bit_idx[2:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            user_q  <= '0;
            user1_q <= '0;
            user2_q <= '0;
        end else if (wr_ok && !addr[AW-1]) begin
            unique case (addr[RW-1:0])
                RW'(OFF_ADDR):  addr_q  <= wdata;
                RW'(OFF_USER):  user_q  <= wdata;
                RW'(OFF_USER1): user1_q <= wdata;
                RW'(OFF_USER2): user2_q <= wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BUF_WORDS; i++) mem[i] <= '0;
        end else if (rx_we) begin
            mem[bw][bp] <= rx_bit;
        end else if (wr_ok && addr[AW-1]) begin
            mem[addr[AW-2:2]] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr[AW-1]) begin
            rdata = mem[addr[AW-2:2]];
        end else begin
            unique case (addr[RW-1:0])
                RW'(OFF_CMD):   rdata[TRIG_BIT] = busy;
                RW'(OFF_ADDR):  rdata = addr_q;
                RW'(OFF_USER):  rdata = user_q;
                RW'(OFF_USER1): rdata = user1_q;
                RW'(OFF_USER2): rdata = user2_q;
                default:        rdata = '0;
            endcase
        end
    end

    assign ph_en     = {user_q[28], user_q[27], user_q[30], user_q[31]};
    assign wide_addr = user_q[1];
    assign cmd_len   = user2_q[31:28];
    assign opcode    = user2_q[7:0];
    assign addr_len  = user1_q[31:26];
    assign dout_len  = user1_q[25:17];
    assign din_len   = user1_q[16:8];
    assign addr_word = addr_q;
    assign tx_bit    = mem[bw][bp];

    // R9: configuration frozen while a transaction runs
    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(user_q) && $stable(user1_q) && $stable(user2_q) && $stable(addr_q)));

    // R1: a trigger is never accepted while busy
    p_no_retrigger_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);
endmodule

// File: rtl/spi_seq_engine.sv
module spi_seq_engine
    import spi_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [3:0]       ph_en,
    input  logic             wide_addr,
    input  logic [3:0]       cmd_len,
    input  logic [5:0]       addr_len,
    input  logic [LEN_W-1:0] dout_len,
    input  logic [LEN_W-1:0] din_len,
    input  logic [7:0]       opcode,
    input  logic [31:0]      addr_word,
    input  logic             tx_bit,
    input  logic             miso,
    output logic             busy,
    output logic [LEN_W-1:0] bit_idx,
    output logic             rx_we,
    output logic             rx_bit,
    output logic             sck,
    output logic             mosi
);
    seq_state_t state, nxt;
    logic             ph;
    logic [LEN_W-1:0] cnt, len_cur;
    logic [7:0]       sh_cmd;
    logic [31:0]      sh_addr;
    logic [5:0]       alen;
    logic             in_phase, last_bit;

    function automatic seq_state_t pick(input logic [3:0] e, input int from);
        seq_state_t r = ST_DONE;
        for (int i = 3; i >= 0; i--)
            if (i >= from && e[i]) r = seq_state_t'(3'(i + 1));
        return r;
    endfunction

    assign alen     = (wide_addr || addr_len <= 6'd23) ? addr_len : 6'd23;
    assign in_phase = (state == ST_CMD) || (state == ST_ADDR) ||
                      (state == ST_DOUT) || (state == ST_DIN);
    assign last_bit = in_phase && ph && (cnt == len_cur);

    always_comb begin
        unique case (state)
            ST_CMD:  len_cur = LEN_W'(cmd_len);
            ST_ADDR: len_cur = LEN_W'(alen);
            ST_DOUT: len_cur = dout_len;
            ST_DIN:  len_cur = din_len;
            default: len_cur = '0;
        endcase
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = pick(ph_en, 0);
            ST_CMD, ST_ADDR, ST_DOUT, ST_DIN:
                if (last_bit) nxt = pick(ph_en, int'(state));
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // bit timing and shift registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph      <= 1'b0;
            cnt     <= '0;
            sh_cmd  <= '0;
            sh_addr <= '0;
        end else if (state == ST_IDLE && start) begin
            ph      <= 1'b0;
            cnt     <= '0;
            sh_cmd  <= opcode;
            sh_addr <= addr_word;
        end else if (in_phase) begin
            if (!ph) begin
                ph <= 1'b1;
            end else begin
                ph <= 1'b0;
                if (cnt == len_cur) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                    if (state == ST_CMD)  sh_cmd  <= {sh_cmd[6:0], 1'b0};
                    if (state == ST_ADDR) sh_addr <= {sh_addr[30:0], 1'b0};
                end
            end
        end else begin
            ph <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        busy    = (state != ST_IDLE);
        sck     = ph;
        bit_idx = cnt;
        rx_we   = (state == ST_DIN) && !ph;
        rx_bit  = miso;
        unique case (state)
            ST_CMD:  mosi = sh_cmd[7];
            ST_ADDR: mosi = sh_addr[31];
            ST_DOUT: mosi = tx_bit;
            default: mosi = 1'b0;
        endcase
    end

    // R7: SCK low whenever idle
    p_sck_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);
    // R7: MOSI held across the high half of SCK
    p_mosi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> $stable(mosi));
    // R1: busy drops one clock after the finish state
    p_done_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> (state == ST_IDLE));
    // R10: empty trigger goes straight to finish
    p_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ph_en == 4'b0000) |=> (state == ST_DONE));
    // R6: MOSI quiet while reading
    p_din_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DIN) |-> !mosi);
endmodule

// File: rtl/spi_user_seq.sv
module spi_user_seq
    import spi_seq_pkg::*;
#(
    parameter int BUF_WORDS = 16,
    localparam int ADDR_W = $clog2(BUF_WORDS) + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    logic             busy, start, wide_addr, tx_bit, rx_we, rx_bit;
    logic [3:0]       ph_en, cmd_len;
    logic [5:0]       addr_len;
    logic [LEN_W-1:0] dout_len, din_len, bit_idx;
    logic [7:0]       opcode;
    logic [31:0]      addr_word;

    spi_seq_regs #(.BUF_WORDS(BUF_WORDS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .busy(busy), .start(start),
        .ph_en(ph_en), .wide_addr(wide_addr), .cmd_len(cmd_len),
        .addr_len(addr_len), .dout_len(dout_len), .din_len(din_len),
        .opcode(opcode), .addr_word(addr_word), .bit_idx(bit_idx),
        .tx_bit(tx_bit), .rx_we(rx_we), .rx_bit(rx_bit)
    );

    spi_seq_engine u_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .ph_en(ph_en),
        .wide_addr(wide_addr), .cmd_len(cmd_len), .addr_len(addr_len),
        .dout_len(dout_len), .din_len(din_len), .opcode(opcode),
        .addr_word(addr_word), .tx_bit(tx_bit), .miso(spi_miso),
        .busy(busy), .bit_idx(bit_idx), .rx_we(rx_we), .rx_bit(rx_bit),
        .sck(spi_sck), .mosi(spi_mosi)
    );
endmodule

// File: tb/test_spi_user_seq.sv
module test_spi_user_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sck, spi_mosi, spi_miso;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    spi_user_seq i_spi_user_seq (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // flash model: fixed pattern on MISO, advanced at each falling SCK
    localparam logic [63:0] PAT = 64'hC3A5_96F0_1E2D_7B48;
    int  sidx = 0;
    int  nlog = 0;
    logic logd [0:2047];
    assign spi_miso = PAT[63 - (sidx % 64)];
    always @(negedge spi_sck) sidx++;
    always @(posedge spi_sck) begin
        if (nlog < 2048) logd[nlog] = spi_mosi;
        nlog++;
    end

    // R7 monitor: MOSI must not change while SCK is high
    int   mosi_viol = 0;
    logic prev_mosi = 1'b0;
    always @(negedge clk) begin
        if (spi_sck && spi_mosi !== prev_mosi) mosi_viol++;
        prev_mosi = spi_mosi;
    end

    logic [31:0] mdl [16];

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic trigger_and_count(output int bc);
        sidx = 0; nlog = 0;
        wr(7'h00, 32'h0004_0000);
        bc = 0;
        for (int g = 0; g < 5000; g++) begin
            @(negedge clk);
            bus_addr = 7'h00;
            #1;
            if (bus_rdata[18]) bc++;
            else break;
        end
    endtask

    // stimulus table: user, user1, user2, address
    localparam logic [127:0] VT [9] = '{
        {32'h8000_0000, 32'h0000_0000, 32'h7000_009F, 32'h0000_0000},
        {32'hD000_0000, 32'h5C00_1F00, 32'h7000_000B, 32'h1234_5600},
        {32'hC800_0002, 32'h7C1E_0000, 32'h7000_0002, 32'hA5C3_0F71},
        {32'h4000_0000, 32'h7C00_0000, 32'h0000_0000, 32'hDEAD_BEEF},
        {32'h1800_0000, 32'h03FF_FF00, 32'h0000_0000, 32'h0000_0000},
        {32'h1000_0000, 32'h0000_0400, 32'h0000_0000, 32'h0000_0000},
        {32'h8000_0000, 32'h0000_0000, 32'h3000_00C5, 32'h0000_0000},
        {32'h0000_0000, 32'h7C1E_1F00, 32'h7000_0055, 32'h0000_0000},
        {32'hD800_0000, 32'h5C0E_0F00, 32'h7000_0003, 32'h00AB_CD00}
    };

    task automatic run_vec(input int vi, input logic [127:0] v);
        logic [31:0] u, u1, u2, ad, rv;
        int tc, ta, to, tn, tot, bc, f, mc, ma, mo, mi;
        u = v[127:96]; u1 = v[95:64]; u2 = v[63:32]; ad = v[31:0];
        for (int w = 0; w < 16; w++) begin
            mdl[w] = {8'(vi * 16 + w), 8'(w * 3 + 1), 8'(~w), 8'(vi + w * 7)};
            wr(7'(64 + 4 * w), mdl[w]);
        end
        wr(7'h1C, u); wr(7'h20, u1); wr(7'h24, u2); wr(7'h04, ad);
        tc = u[31] ? int'(u2[31:28]) + 1 : 0;
        f  = int'(u1[31:26]);
        ta = u[30] ? ((u[1] ? f : (f > 23 ? 23 : f)) + 1) : 0;
        to = u[27] ? int'(u1[25:17]) + 1 : 0;
        tn = u[28] ? int'(u1[16:8]) + 1 : 0;
        tot = tc + ta + to + tn;
        trigger_and_count(bc);
        check("R1/R8", $sformatf("v%0d busy clocks", vi), bc, 2 * tot + 1);
        check("R7", $sformatf("v%0d sck rises", vi), nlog, tot);
        mc = 0; ma = 0; mo = 0; mi = 0;
        for (int i = 0; i < tc; i++)
            if (logd[i] !== ((i < 8) ? u2[7 - i] : 1'b0)) mc++;
        for (int i = 0; i < ta; i++)
            if (logd[tc + i] !== ((i < 32) ? ad[31 - i] : 1'b0)) ma++;
        for (int n = 0; n < to; n++)
            if (logd[tc + ta + n] !== mdl[n / 32][((n / 8) % 4) * 8 + 7 - (n % 8)]) mo++;
        for (int n = 0; n < tn; n++)
            if (logd[tc + ta + to + n] !== 1'b0) mi++;
        check("R2/R3", $sformatf("v%0d opcode bit errors", vi), mc, 0);
        check("R2/R4", $sformatf("v%0d address bit errors", vi), ma, 0);
        check("R2/R5", $sformatf("v%0d write-data bit errors", vi), mo, 0);
        check("R6", $sformatf("v%0d mosi during read", vi), mi, 0);
        for (int n = 0; n < tn; n++)
            mdl[n / 32][((n / 8) % 4) * 8 + 7 - (n % 8)] = PAT[63 - ((tc + ta + to + n) % 64)];
        for (int w = 0; w < 16; w++) begin
            rd(7'(64 + 4 * w), rv);
            check("R6", $sformatf("v%0d buffer word %0d", vi, w), rv, mdl[w]);
        end
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int bc;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R12 reset state
        check("R12", "sck", 32'(spi_sck), 0);
        check("R12", "mosi", 32'(spi_mosi), 0);
        rd(7'h00, r); check("R12", "cmd", r, 0);
        rd(7'h04, r); check("R12", "addr", r, 0);
        rd(7'h1C, r); check("R12", "user", r, 0);
        rd(7'h20, r); check("R12", "user1", r, 0);
        rd(7'h24, r); check("R12", "user2", r, 0);
        rd(7'h7C, r); check("R12", "buffer last", r, 0);

        // R11 register map readback
        wr(7'h04, 32'h1111_2222); rd(7'h04, r); check("R11", "addr", r, 32'h1111_2222);
        wr(7'h1C, 32'h0000_00F0); rd(7'h1C, r); check("R11", "user", r, 32'h0000_00F0);
        wr(7'h20, 32'h3333_4444); rd(7'h20, r); check("R11", "user1", r, 32'h3333_4444);
        wr(7'h24, 32'h0555_6666); rd(7'h24, r); check("R11", "user2", r, 32'h0555_6666);
        wr(7'h48, 32'h7777_8888); rd(7'h48, r); check("R11", "buffer word 2", r, 32'h7777_8888);
        wr(7'h00, 32'hFFFB_FFFF); rd(7'h00, r); check("R11", "cmd without trigger", r, 0);

        // table walk
        foreach (VT[k]) run_vec(k, VT[k]);

        // R10 directed: empty trigger
        wr(7'h1C, 32'h0000_0002);
        trigger_and_count(bc);
        check("R10", "empty busy clocks", bc, 1);
        check("R10", "empty sck rises", nlog, 0);

        // R9 directed: writes and retrigger while busy
        wr(7'h1C, 32'h0800_0000); wr(7'h20, 32'h003E_0000);
        wr(7'h24, 32'h7000_0001); wr(7'h04, 32'h0102_0304);
        wr(7'h4C, 32'hCAFE_F00D);
        sidx = 0; nlog = 0;
        wr(7'h00, 32'h0004_0000);
        wr(7'h1C, 32'hFFFF_FFFF); wr(7'h20, 32'h0);
        wr(7'h24, 32'h0);         wr(7'h04, 32'hFFFF_FFFF);
        wr(7'h4C, 32'h0BAD_0BAD); wr(7'h00, 32'h0004_0000);
        for (int g = 0; g < 200; g++) begin
            rd(7'h00, r);
            if (!r[18]) break;
        end
        rd(7'h1C, r); check("R9", "user after busy write", r, 32'h0800_0000);
        rd(7'h20, r); check("R9", "user1 after busy write", r, 32'h003E_0000);
        rd(7'h24, r); check("R9", "user2 after busy write", r, 32'h7000_0001);
        rd(7'h04, r); check("R9", "addr after busy write", r, 32'h0102_0304);
        rd(7'h4C, r); check("R9", "buffer after busy write", r, 32'hCAFE_F00D);
        check("R9", "no retrigger sck rises", nlog, 32);
        rd(7'h00, r); check("R1", "trigger bit cleared", r, 0);

        check("R7", "mosi changes while sck high", mosi_viol, 0);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule